// File: doc/BRIEF.md
# Presence-Tracked Memory-Mapped I/O Front End

This block sits ahead of a memory node's storage and serves one READ or WRITE request per cycle. The request address is sorted into four regions. The lowest region holds cells with a presence bit. The second region holds a small set of device registers. The third is a read-only boot area whose contents are computed from the address. Everything above that is plain raw storage. A read of an empty presence cell, or of the empty receive register, is not answered at once. It is parked in the block's single deferred-read slot until data arrives, and the answer then goes out as a result token carrying the tag that the requester supplied.

A byte-wide producer port feeds the receive register. A consumer can therefore issue one read and simply wait for the byte, with no polling and no interrupt. The status register is never deferred, so software can still probe the device state. Writes to the device range go straight to the transmit or configuration register. Writes to the boot area are dropped and flagged.

Top module: `pmio_front`

## Requirements
- R1: The request address selects a region: below 0x100 are presence cells, 0x100 to 0x1FF are I/O registers, 0x200 to 0x3FF is boot storage, and 0x400 and above is raw storage (cell index taken from the low 8 bits).
- R2: An accepted READ of a presence cell whose presence bit is set gives rsp_valid on the next cycle, carrying the stored data and the request's tag. The cell stays full.
- R3: A READ of an empty presence cell gives no response and parks in the slot. A later WRITE to that cell stores the data, sets the cell full, and on the next cycle answers the parked read with the written data and the parked tag.
- R4: Only one read may be parked at a time. A read that would defer while the slot is occupied gives rsp_refused (never together with rsp_valid) on the next cycle, with its own tag on rsp_tag.
- R5: A write to a full location overwrites it (one-deep buffer). This holds both for presence cells and for device bytes written into the receive register.
- R6: I/O offset 1 is receive data. A read returns the byte at once when one is present and empties the register. Otherwise the read parks, and the next device byte answers it one cycle after dev_rx_valid while leaving the register empty. A device byte arriving in the same cycle as the read is returned directly.
- R7: I/O offset 2 is status and is answered on the next cycle without deferral. Bit 0 is receive-full, bit 1 is tx_busy, and the other bits are 0.
- R8: A WRITE to I/O offset 0 gives a one-cycle tx_valid pulse with tx_data on the next cycle. A WRITE to offset 3 sets cfg_out on the next cycle. Other I/O writes change nothing, and I/O reads of offsets other than 1 and 2 return 0 at once.
- R9: A boot read at offset n (address minus 0x200) returns (7*n+3) mod 256 on the next cycle. A boot write changes nothing, gives no response, and pulses boot_wr_err for one cycle on the next cycle.
- R10: Raw storage returns the last written value on the next cycle and never defers.
- R11: req_ready is low only in a cycle where the slot holds a receive read and dev_rx_valid is high. That device answer takes precedence, and the held request is served afterwards.
- R12: After reset every presence cell and the receive register are empty, the slot is free, cfg_out is 0, and no response, refusal, error or tx pulse is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = WRITE, 0 = READ |
| req_addr | input | ADDR_W (11) | Cell address |
| req_wdata | input | DATA_W (8) | Write data |
| req_tag | input | TAG_W (4) | Return tag of the requester |
| rsp_valid | output | 1 | Result token valid |
| rsp_refused | output | 1 | Read refused because the slot is occupied |
| rsp_data | output | DATA_W (8) | Result data |
| rsp_tag | output | TAG_W (4) | Return tag of the answered or refused read |
| boot_wr_err | output | 1 | Pulse on a write to boot storage |
| dev_rx_valid | input | 1 | Device delivers a received byte |
| dev_rx_data | input | DATA_W (8) | Received byte |
| tx_busy | input | 1 | Transmitter busy, reported in status |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_data | output | DATA_W (8) | Transmit byte |
| cfg_out | output | DATA_W (8) | Configuration register |

## Verification
A wrong presence bit shows up at the ports on the cycle after the next read of that cell. Either a response appears where the read should have parked, or the read parks and a later unrelated read is refused. A corrupted slot address or tag shows when the satisfying write arrives: the answer is missing, or it carries the wrong data or tag, again one cycle after the event. Receive-register state leaks into the status word, so a stale full bit can be seen on the next status read without waiting for any deferral.

// File: rtl/pmio_pkg.sv
package pmio_pkg;
  typedef enum logic [1:0] {REG_CELL = 2'd0, REG_IO = 2'd1, REG_BOOT = 2'd2, REG_RAW = 2'd3} region_e;
  typedef enum logic [1:0] {SRC_CELL = 2'd0, SRC_RAW = 2'd1, SRC_DIRECT = 2'd2} src_e;
  localparam int IO_TX   = 0;
  localparam int IO_RX   = 1;
  localparam int IO_STAT = 2;
  localparam int IO_CFG  = 3;
endpackage

// File: rtl/pmio_decode.sv
module pmio_decode
  import pmio_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int TIER   = 256
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] LIM_CELL = ADDR_W'(TIER);
  localparam logic [ADDR_W-1:0] LIM_IO   = ADDR_W'(2 * TIER);
  localparam logic [ADDR_W-1:0] LIM_BOOT = ADDR_W'(4 * TIER);

  always_comb begin
    if (addr < LIM_CELL)      region = REG_CELL;
    else if (addr < LIM_IO)   region = REG_IO;
    else if (addr < LIM_BOOT) region = REG_BOOT;
    else                      region = REG_RAW;
  end
endmodule

// File: rtl/pmio_ram.sv
module pmio_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rq
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-before-write, registered read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rq <= mem[addr];
  end
endmodule

// File: rtl/pmio_cells.sv
module pmio_cells #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     idx,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              full,
  output logic [DATA_W-1:0] rq
);
  logic [DEPTH-1:0] present;

  pmio_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk(clk), .we(we), .addr(idx), .wdata(wdata), .rq(rq)
  );

  always_ff @(posedge clk) begin
    if (rst)     present <= '0;
    else if (we) present[idx] <= 1'b1;
  end

  assign full = present[idx];
endmodule

// File: rtl/pmio_io.sv
module pmio_io
  import pmio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rx_take,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              rx_wait,
  input  logic              tx_busy,
  output logic              rx_full_eff,
  output logic [DATA_W-1:0] rx_data_eff,
  output logic [DATA_W-1:0] status,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] cfg
);
  logic              rx_full;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full <= 1'b0;
      rx_q    <= '0;
    end else if (rx_take) begin
      rx_full <= 1'b0;
    end else if (dev_valid && !rx_wait) begin
      rx_full <= 1'b1;
      rx_q    <= dev_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      cfg      <= '0;
    end else begin
      tx_valid <= wr_en && (off == OFF_W'(IO_TX));
      if (wr_en && (off == OFF_W'(IO_TX)))  tx_data <= wdata;
      if (wr_en && (off == OFF_W'(IO_CFG))) cfg <= wdata;
    end
  end

  assign rx_full_eff = rx_full | dev_valid;
  assign rx_data_eff = dev_valid ? dev_data : rx_q;
  assign status      = DATA_W'({tx_busy, rx_full});
endmodule

// File: rtl/pmio_front.sv
module pmio_front
  import pmio_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int TAG_W     = 4,
  parameter int TIER      = 256,
  parameter int RAW_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic              rsp_refused,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              boot_wr_err,
  input  logic              dev_rx_valid,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              tx_busy,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] cfg_out
);
  localparam int IDX_W  = $clog2(TIER);
  localparam int BOOT_W = IDX_W + 1;
  localparam int RAW_IW = $clog2(RAW_DEPTH);

  region_e           region;
  logic [IDX_W-1:0]  idx;
  logic              acc, is_rd, is_wr;
  logic              cell_full, rx_full_eff;
  logic [DATA_W-1:0] cell_q, raw_q, rx_data_eff, status, boot_val;
  logic              cell_rd, rx_rd, want_defer, park, refuse;
  logic              dev_answer, cell_answer, rx_wait;
  logic              slot_busy, slot_rx;
  logic [IDX_W-1:0]  slot_idx;
  logic [TAG_W-1:0]  slot_tag;
  logic              nxt_valid;
  src_e              nxt_src, src_q;
  logic [DATA_W-1:0] nxt_data, direct_q;
  logic [TAG_W-1:0]  nxt_tag;

  pmio_decode #(.ADDR_W(ADDR_W), .TIER(TIER)) i_decode (.addr(req_addr), .region(region));

  assign idx      = req_addr[IDX_W-1:0];
  assign rx_wait  = slot_busy && slot_rx;
  assign dev_answer = rx_wait && dev_rx_valid;
  assign req_ready  = !dev_answer;
  assign acc      = req_valid && req_ready;
  assign is_rd    = acc && !req_write;
  assign is_wr    = acc && req_write;
  assign cell_rd  = is_rd && (region == REG_CELL);
  assign rx_rd    = is_rd && (region == REG_IO) && (idx == IDX_W'(IO_RX));
  assign want_defer = (cell_rd && !cell_full) || (rx_rd && !rx_full_eff);
  assign park     = want_defer && !slot_busy;
  assign refuse   = want_defer && slot_busy;
  assign cell_answer = is_wr && (region == REG_CELL) && slot_busy && !slot_rx && (slot_idx == idx);
  assign boot_val = DATA_W'(req_addr[BOOT_W-1:0]) * DATA_W'(7) + DATA_W'(3);

  pmio_cells #(.DATA_W(DATA_W), .DEPTH(TIER)) i_cells (
    .clk(clk), .rst(rst), .idx(idx), .we(is_wr && (region == REG_CELL)),
    .wdata(req_wdata), .full(cell_full), .rq(cell_q)
  );

  pmio_ram #(.DATA_W(DATA_W), .DEPTH(RAW_DEPTH)) i_raw (
    .clk(clk), .we(is_wr && (region == REG_RAW)), .addr(req_addr[RAW_IW-1:0]),
    .wdata(req_wdata), .rq(raw_q)
  );

  pmio_io #(.DATA_W(DATA_W), .OFF_W(IDX_W)) i_io (
    .clk(clk), .rst(rst), .wr_en(is_wr && (region == REG_IO)),
    .rx_take(rx_rd && rx_full_eff), .off(idx), .wdata(req_wdata),
    .dev_valid(dev_rx_valid), .dev_data(dev_rx_data), .rx_wait(rx_wait),
    .tx_busy(tx_busy), .rx_full_eff(rx_full_eff), .rx_data_eff(rx_data_eff),
    .status(status), .tx_valid(tx_valid), .tx_data(tx_data), .cfg(cfg_out)
  );

  // deferred-read slot
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_busy <= 1'b0;
      slot_rx   <= 1'b0;
      slot_idx  <= '0;
      slot_tag  <= '0;
    end else if (dev_answer || cell_answer) begin
      slot_busy <= 1'b0;
    end else if (park) begin
      slot_busy <= 1'b1;
      slot_rx   <= (region == REG_IO);
      slot_idx  <= idx;
      slot_tag  <= req_tag;
    end
  end

  // response selection
  always_comb begin
    nxt_valid = 1'b0;
    nxt_src   = SRC_DIRECT;
    nxt_data  = '0;
    nxt_tag   = req_tag;
    if (dev_answer) begin
      nxt_valid = 1'b1;
      nxt_data  = dev_rx_data;
      nxt_tag   = slot_tag;
    end else if (cell_answer) begin
      nxt_valid = 1'b1;
      nxt_data  = req_wdata;
      nxt_tag   = slot_tag;
    end else if (is_rd) begin
      unique case (region)
        REG_CELL: begin
          nxt_valid = cell_full;
          nxt_src   = SRC_CELL;
        end
        REG_IO: begin
          if (idx == IDX_W'(IO_RX)) begin
            nxt_valid = rx_full_eff;
            nxt_data  = rx_data_eff;
          end else begin
            nxt_valid = 1'b1;
            if (idx == IDX_W'(IO_STAT)) nxt_data = status;
          end
        end
        REG_BOOT: begin
          nxt_valid = 1'b1;
          nxt_data  = boot_val;
        end
        default: begin
          nxt_valid = 1'b1;
          nxt_src   = SRC_RAW;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_refused <= 1'b0;
      rsp_tag     <= '0;
      src_q       <= SRC_DIRECT;
      direct_q    <= '0;
      boot_wr_err <= 1'b0;
    end else begin
      rsp_valid   <= nxt_valid;
      rsp_refused <= refuse;
      rsp_tag     <= nxt_tag;
      src_q       <= nxt_src;
      direct_q    <= nxt_data;
      boot_wr_err <= is_wr && (region == REG_BOOT);
    end
  end

  assign rsp_data = (src_q == SRC_CELL) ? cell_q : (src_q == SRC_RAW) ? raw_q : direct_q;
endmodule

// File: rtl/pmio_chk.sv
module pmio_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int TIER   = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              dev_rx_valid,
  input logic              rsp_valid,
  input logic              rsp_refused,
  input logic              boot_wr_err,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data
);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(TIER);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(TIER + 2);
  localparam logic [ADDR_W-1:0] A_BOOT = ADDR_W'(2 * TIER);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(4 * TIER);

  logic acc;
  assign acc = req_valid && req_ready;

  // R4
  no_dual_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_refused));

  // R11
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> dev_rx_valid);

  // R9
  boot_err_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_write && req_addr >= A_BOOT && req_addr < A_RAW) |=> (boot_wr_err && !rsp_valid));

  // R9
  boot_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    boot_wr_err |-> $past(acc && req_write && req_addr >= A_BOOT && req_addr < A_RAW));

  // R8
  tx_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_write && req_addr == A_TX) |=> (tx_valid && tx_data == $past(req_wdata)));

  // R7
  status_now_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_write && req_addr == A_STAT) |=> (rsp_valid && !rsp_refused));
endmodule

bind pmio_front pmio_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIER(TIER)) i_pmio_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .dev_rx_valid(dev_rx_valid), .rsp_valid(rsp_valid), .rsp_refused(rsp_refused),
  .boot_wr_err(boot_wr_err), .tx_valid(tx_valid), .tx_data(tx_data)
);

// File: tb/test_pmio_front.sv
module test_pmio_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [3:0]  req_tag = '0;
  logic        rsp_valid, rsp_refused, boot_wr_err, tx_valid;
  logic [7:0]  rsp_data, tx_data, cfg_out;
  logic [3:0]  rsp_tag;
  logic        dev_rx_valid = 1'b0, tx_busy = 1'b0;
  logic [7:0]  dev_rx_data = '0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pmio_front i_pmio_front (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_refused(rsp_refused), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .boot_wr_err(boot_wr_err), .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
    .tx_busy(tx_busy), .tx_valid(tx_valid), .tx_data(tx_data), .cfg_out(cfg_out)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [10:0] a, input logic [7:0] d, input logic [3:0] t);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_tag = t;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string r, input logic [7:0] d, input logic [3:0] t);
    chk(rsp_valid === 1'b1 && rsp_refused === 1'b0, r, {rsp_valid, rsp_refused}, 2);
    chk(rsp_data === d, r, rsp_data, d);
    chk(rsp_tag === t, r, rsp_tag, t);
  endtask

  task automatic expect_none(input string r);
    chk(rsp_valid === 1'b0 && rsp_refused === 1'b0, r, {rsp_valid, rsp_refused}, 0);
  endtask

  task automatic dev_byte(input logic [7:0] d);
    @(negedge clk);
    dev_rx_valid = 1'b1; dev_rx_data = d;
    @(negedge clk);
    dev_rx_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!rsp_valid && !rsp_refused && !boot_wr_err && !tx_valid, "R12", 1, 0);
    chk(cfg_out === 8'h00, "R12", cfg_out, 0);
    chk(req_ready === 1'b1, "R12", req_ready, 1);
    op(1'b0, 11'h102, 8'h00, 4'h1);
    expect_rsp("R12", 8'h00, 4'h1);

    // R3 R4 R2 sweep over all presence cells
    for (int a = 0; a < 256; a++) begin
      op(1'b0, 11'(a), 8'h00, 4'(a));
      expect_none("R3");
      if (a < 255) begin
        op(1'b0, 11'(a + 1), 8'h00, ~4'(a));
        chk(rsp_refused === 1'b1 && rsp_valid === 1'b0, "R4", {rsp_refused, rsp_valid}, 2);
        chk(rsp_tag === ~4'(a), "R4", rsp_tag, ~4'(a));
      end
      op(1'b1, 11'(a), 8'((a * 3 + 1) % 256), 4'h0);
      expect_rsp("R3", 8'((a * 3 + 1) % 256), 4'(a));
      op(1'b0, 11'(a), 8'h00, 4'h5);
      expect_rsp("R2", 8'((a * 3 + 1) % 256), 4'h5);
    end

    // R5 overwrite of a full cell
    op(1'b1, 11'd10, 8'h77, 4'h0);
    expect_none("R5");
    op(1'b0, 11'd10, 8'h00, 4'h6);
    expect_rsp("R5", 8'h77, 4'h6);

    // R1 boundaries
    op(1'b0, 11'h0FF, 8'h00, 4'h2);
    expect_rsp("R1", 8'hFE, 4'h2);
    op(1'b0, 11'h1FF, 8'h00, 4'h3);
    expect_rsp("R1", 8'h00, 4'h3);
    op(1'b0, 11'h200, 8'h00, 4'h4);
    expect_rsp("R1", 8'h03, 4'h4);
    op(1'b0, 11'h3FF, 8'h00, 4'h5);
    expect_rsp("R1", 8'hFC, 4'h5);
    op(1'b1, 11'h400, 8'h3C, 4'h0);
    expect_none("R1");
    op(1'b0, 11'h400, 8'h00, 4'h7);
    expect_rsp("R1", 8'h3C, 4'h7);

    // R9 boot sweep, write ignored
    for (int i = 0; i < 512; i++) begin
      op(1'b0, 11'(512 + i), 8'h00, 4'(i));
      expect_rsp("R9", 8'((i * 7 + 3) % 256), 4'(i));
    end
    op(1'b1, 11'h205, 8'hEE, 4'h0);
    chk(boot_wr_err === 1'b1, "R9", boot_wr_err, 1);
    expect_none("R9");
    @(negedge clk);
    chk(boot_wr_err === 1'b0, "R9", boot_wr_err, 0);
    op(1'b0, 11'h205, 8'h00, 4'h8);
    expect_rsp("R9", 8'd38, 4'h8);

    // R10 raw storage sweep
    for (int i = 0; i < 256; i++) op(1'b1, 11'(1024 + i), 8'(i ^ 8'h5A), 4'h0);
    for (int i = 0; i < 256; i++) begin
      op(1'b0, 11'(1024 + i), 8'h00, 4'(i));
      expect_rsp("R10", 8'(i ^ 8'h5A), 4'(i));
    end

    // R8 transmit and config
    op(1'b1, 11'h100, 8'h41, 4'h0);
    chk(tx_valid === 1'b1 && tx_data === 8'h41, "R8", tx_data, 8'h41);
    @(negedge clk);
    chk(tx_valid === 1'b0, "R8", tx_valid, 0);
    op(1'b1, 11'h103, 8'h9C, 4'h0);
    chk(cfg_out === 8'h9C, "R8", cfg_out, 8'h9C);
    op(1'b1, 11'h101, 8'h11, 4'h0);
    op(1'b0, 11'h102, 8'h00, 4'h1);
    expect_rsp("R8", 8'h00, 4'h1);
    op(1'b0, 11'h100, 8'h00, 4'h2);
    expect_rsp("R8", 8'h00, 4'h2);

    // R7 status with transmitter busy
    tx_busy = 1'b1;
    op(1'b0, 11'h102, 8'h00, 4'h3);
    expect_rsp("R7", 8'h02, 4'h3);
    tx_busy = 1'b0;

    // R6 R5 receive register
    dev_byte(8'h33);
    op(1'b0, 11'h102, 8'h00, 4'h4);
    expect_rsp("R7", 8'h01, 4'h4);
    dev_byte(8'h44);
    op(1'b0, 11'h101, 8'h00, 4'h5);
    expect_rsp("R5", 8'h44, 4'h5);
    op(1'b0, 11'h102, 8'h00, 4'h6);
    expect_rsp("R6", 8'h00, 4'h6);
    op(1'b0, 11'h101, 8'h00, 4'h9);
    expect_none("R6");
    op(1'b0, 11'h102, 8'h00, 4'hA);
    expect_rsp("R7", 8'h00, 4'hA);

    // R11 device answer wins over a concurrent request
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h007; req_tag = 4'h3;
    dev_rx_valid = 1'b1; dev_rx_data = 8'h55;
    #1 chk(req_ready === 1'b0, "R11", req_ready, 0);
    @(negedge clk);
    dev_rx_valid = 1'b0;
    expect_rsp("R11", 8'h55, 4'h9);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R11", 8'd22, 4'h3);
    op(1'b0, 11'h102, 8'h00, 4'hB);
    expect_rsp("R6", 8'h00, 4'hB);

    // R6 byte arriving with the read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h101; req_tag = 4'h2;
    dev_rx_valid = 1'b1; dev_rx_data = 8'h66;
    @(negedge clk);
    req_valid = 1'b0; dev_rx_valid = 1'b0;
    expect_rsp("R6", 8'h66, 4'h2);
    op(1'b0, 11'h102, 8'h00, 4'hC);
    expect_rsp("R6", 8'h00, 4'hC);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule